// File: doc/BRIEF.md
# Capability Load Controller With Delegated Integrity Gate

This block loads a capability into a destination register of a small capability register file that it holds itself. A one-cycle `sub_start` pulse hands it a source register select, a destination select, an index and an optional direct token. Without a direct token, the block reads the source capability. It checks the load permission, unless `elevated` is set. It checks the index against the source limit. It then reads the token word from capability-list memory at the source base plus the index. With a direct token, the source read and both checks are skipped.

The token's slot number is compared with the namespace limit held in the namespace register. The token is then passed to an external integrity gate through a one-cycle start pulse. The controller waits for the gate to report done or fault, and latches either the gate's three raw entry words or its fault kind. After a good gate result the controller may do two memory writes. When seal checking is enabled, it writes the entry's third word back with the g-bit cleared. When the destination select is 7 or lower, it writes the token into a mirror area. It then writes the loaded capability into the destination register and pulses `sub_done`. Any failure ends in `sub_fault`, with a fault code that holds until the next start.

States and transitions: IDLE → READ_SRC on start without a direct token, or IDLE → CHECK_NS with a direct token. READ_SRC → CHECK_ACCESS. CHECK_ACCESS → FETCH_TOK when both checks pass, otherwise → FAULT. FETCH_TOK → TOK_WAIT. TOK_WAIT → CHECK_NS. CHECK_NS → START_GATE when the slot is in range, otherwise → FAULT. START_GATE → WAIT_GATE. WAIT_GATE goes on gate done to CLEAR_GBIT when seal checking is on, else to MIRROR or COMPLETE. WAIT_GATE goes on gate fault to FAULT. CLEAR_GBIT → MIRROR or COMPLETE. MIRROR → COMPLETE. COMPLETE → IDLE. FAULT → IDLE. FETCH_TOK, CLEAR_GBIT and MIRROR wait while `gate_busy` is high.

Top module: `cap_loader`

## Requirements
- R1: After reset, `sub_done`, `sub_fault`, `gate_start`, `mem_rd_en` and `mem_wr_en` are low, `fault_code` is 0 and every register reads zero.
- R2: With `direct_valid` set at start, `direct_token` is used as the token, and no source read, permission check, bounds check or memory read takes place.
- R3: A register holds three 32-bit words {w2,w1,w0}. Source w0 bit 0 is the load permission. When it is clear and `elevated` is low, the load faults with code 1 (permission). `elevated` high bypasses this check.
- R4: The source limit is w0[27:16]. An index greater than or equal to the limit faults with code 2 (bounds). Index = limit−1 is accepted.
- R5: Without a direct token, the token is the memory word at address source w1 + index. It is read through a port that returns data one cycle after `mem_rd_en`.
- R6: The slot is token[11:0]. A slot not below w2 of register 15 (the namespace register) faults with code 3, and `gate_start` is never raised.
- R7: `gate_start` is a one-cycle pulse carrying the token on `gate_token`. The block drives no memory read or write while `gate_busy` is high.
- R8: A gate fault ends the load with `sub_fault` and code 4 when `gate_fault_kind` is 0 (version) or code 5 when it is 1 (seal). On any fault the destination register and memory are left unchanged.
- R9: With seal checking on, after gate done the block writes the gate's raw word 3 with bit 16 cleared to address w1(reg 15) + 3·slot + 2.
- R10: The token is written to address `MIRROR_BASE` + destination select only when the destination select is 7 or lower.
- R11: On success, the destination register becomes {raw word 2, raw base, token} and `sub_done` pulses for one cycle with `fault_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sub_start | input | 1 | Start pulse for one load |
| src_sel | input | RSEL_W | Source register select |
| dst_sel | input | RSEL_W | Destination register select |
| index | input | IDX_W | Index into the source capability list |
| direct_valid | input | 1 | Use `direct_token` instead of a source fetch |
| direct_token | input | 32 | Directly supplied token |
| elevated | input | 1 | Bypass the load permission check |
| sub_done | output | 1 | Load completed |
| sub_fault | output | 1 | Load failed |
| fault_code | output | 3 | Latched fault code (0 none, 1..5) |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| gate_start | output | 1 | Gate start pulse |
| gate_token | output | 32 | Token handed to the gate |
| gate_ns_base | output | 32 | Namespace table base for the gate |
| gate_busy | input | 1 | Gate owns the memory bus |
| gate_done | input | 1 | Gate passed |
| gate_fault | input | 1 | Gate failed |
| gate_fault_kind | input | 1 | 0 version, 1 seal |
| gate_raw_base | input | 32 | Raw entry word 1 |
| gate_raw_w2 | input | 32 | Raw entry word 2 |
| gate_raw_w3 | input | 32 | Raw entry word 3 |
| rf_wr_en | input | 1 | External register write |
| rf_wr_sel | input | RSEL_W | External write select |
| rf_wr_data | input | 96 | External write data |
| rf_rd_sel | input | RSEL_W | External read select |
| rf_rd_data | output | 96 | External read data |

## Verification
A wrong transition out of CHECK_ACCESS or CHECK_NS shows at once as a wrong `fault_code`. It also changes the number of `gate_start` pulses, and both are visible at the end of the same load. A corrupted latched token or raw word stays internal until COMPLETE or CLEAR_GBIT. It then appears as a wrong destination register, a wrong g-bit word or a wrong mirror word, each read back within two cycles of `sub_done`. A bus driven while the gate is busy is counted by the bench in the cycle it happens.

// File: rtl/cap_load_pkg.sv
package cap_load_pkg;
    localparam int WORD_W = 32;
    localparam int LOAD_PERM_BIT = 0;
    localparam int LIMIT_LSB = 16;

    typedef struct packed {
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } capreg_t;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_PERM    = 3'd1,
        FLT_BOUNDS  = 3'd2,
        FLT_NSLIM   = 3'd3,
        FLT_VERSION = 3'd4,
        FLT_SEAL    = 3'd5
    } fault_e;

    typedef enum logic [3:0] {
        S_IDLE, S_READ_SRC, S_CHECK_ACCESS, S_FETCH_TOK, S_TOK_WAIT,
        S_CHECK_NS, S_START_GATE, S_WAIT_GATE, S_CLEAR_GBIT, S_MIRROR,
        S_COMPLETE, S_FAULT
    } state_e;
endpackage

// File: rtl/cap_regfile.sv
module cap_regfile
    import cap_load_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NS_SEL = 15,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RSEL_W-1:0] wr_sel,
    input  capreg_t           wr_data,
    input  logic [RSEL_W-1:0] a_sel,
    output capreg_t           a_data,
    input  logic [RSEL_W-1:0] b_sel,
    output capreg_t           b_data,
    output capreg_t           ns_data
);
    capreg_t regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_sel] <= wr_data;
        end
    end

    assign a_data  = regs[a_sel];
    assign b_data  = regs[b_sel];
    assign ns_data = regs[NS_SEL];
endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
    import cap_load_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [WORD_W-1:0] w0,
    input  logic [IDX_W-1:0]  index,
    input  logic              elevated,
    output logic              perm_ok,
    output logic              bounds_ok
);
    logic [IDX_W-1:0] limit;
    logic unused_w0_bits;

    assign limit          = w0[LIMIT_LSB +: IDX_W];
    assign perm_ok        = w0[LOAD_PERM_BIT] | elevated;
    assign bounds_ok      = index < limit;
    assign unused_w0_bits = ^{w0[WORD_W-1:LIMIT_LSB+IDX_W], w0[LIMIT_LSB-1:LOAD_PERM_BIT+1]};
endmodule

// File: rtl/cap_loader.sv
module cap_loader
    import cap_load_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NS_SEL = 15,
    parameter int ADDR_W = 16,
    parameter int IDX_W = 12,
    parameter int SLOT_W = 12,
    parameter int MIRROR_BASE = 1500,
    parameter int MIRROR_MAX = 7,
    parameter int GBIT_POS = 16,
    parameter bit SEAL_EN = 1'b1,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_start,
    input  logic [RSEL_W-1:0] src_sel,
    input  logic [RSEL_W-1:0] dst_sel,
    input  logic [IDX_W-1:0]  index,
    input  logic              direct_valid,
    input  logic [31:0]       direct_token,
    input  logic              elevated,
    output logic              sub_done,
    output logic              sub_fault,
    output logic [2:0]        fault_code,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              gate_start,
    output logic [31:0]       gate_token,
    output logic [31:0]       gate_ns_base,
    input  logic              gate_busy,
    input  logic              gate_done,
    input  logic              gate_fault,
    input  logic              gate_fault_kind,
    input  logic [31:0]       gate_raw_base,
    input  logic [31:0]       gate_raw_w2,
    input  logic [31:0]       gate_raw_w3,
    input  logic              rf_wr_en,
    input  logic [RSEL_W-1:0] rf_wr_sel,
    input  logic [95:0]       rf_wr_data,
    input  logic [RSEL_W-1:0] rf_rd_sel,
    output logic [95:0]       rf_rd_data
);
    state_e            state_q, state_d;
    capreg_t           src_q, src_rd, rd_b, ns_reg, rf_wdata;
    logic [RSEL_W-1:0] srcsel_q, dst_q, rf_wsel;
    logic [IDX_W-1:0]  idx_q;
    logic              elev_q, rf_we, perm_ok, bounds_ok, mirror_hit, slot_ok;
    logic [31:0]       token_q, raw_base_q, raw_w2_q, raw_w3_q;
    logic [SLOT_W-1:0] slot;
    fault_e            fault_q;

    assign slot       = token_q[SLOT_W-1:0];
    assign slot_ok    = 32'(slot) < ns_reg.w2;
    assign mirror_hit = 32'(dst_q) <= 32'(MIRROR_MAX);

    // register file: the FSM write in COMPLETE takes priority
    assign rf_we    = (state_q == S_COMPLETE) | rf_wr_en;
    assign rf_wsel  = (state_q == S_COMPLETE) ? dst_q : rf_wr_sel;
    assign rf_wdata = (state_q == S_COMPLETE) ? capreg_t'({raw_w2_q, raw_base_q, token_q})
                                              : capreg_t'(rf_wr_data);

    cap_regfile #(.NREG(NREG), .NS_SEL(NS_SEL)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_sel(rf_wsel), .wr_data(rf_wdata),
        .a_sel(srcsel_q), .a_data(src_rd), .b_sel(rf_rd_sel), .b_data(rd_b),
        .ns_data(ns_reg)
    );
    assign rf_rd_data = rd_b;

    cap_access_check #(.IDX_W(IDX_W)) i_check (
        .w0(src_q.w0), .index(idx_q), .elevated(elev_q),
        .perm_ok(perm_ok), .bounds_ok(bounds_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:         if (sub_start) state_d = direct_valid ? S_CHECK_NS : S_READ_SRC;
            S_READ_SRC:     state_d = S_CHECK_ACCESS;
            S_CHECK_ACCESS: state_d = (perm_ok && bounds_ok) ? S_FETCH_TOK : S_FAULT;
            S_FETCH_TOK:    if (!gate_busy) state_d = S_TOK_WAIT;
            S_TOK_WAIT:     state_d = S_CHECK_NS;
            S_CHECK_NS:     state_d = slot_ok ? S_START_GATE : S_FAULT;
            S_START_GATE:   state_d = S_WAIT_GATE;
            S_WAIT_GATE: begin
                if (gate_fault)     state_d = S_FAULT;
                else if (gate_done) state_d = SEAL_EN ? S_CLEAR_GBIT
                                            : (mirror_hit ? S_MIRROR : S_COMPLETE);
            end
            S_CLEAR_GBIT:   if (!gate_busy) state_d = mirror_hit ? S_MIRROR : S_COMPLETE;
            S_MIRROR:       if (!gate_busy) state_d = S_COMPLETE;
            S_COMPLETE:     state_d = S_IDLE;
            S_FAULT:        state_d = S_IDLE;
            default:        state_d = S_IDLE;
        endcase
    end

    // datapath latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0; srcsel_q <= '0; dst_q <= '0; idx_q <= '0; elev_q <= 1'b0;
            token_q <= '0; raw_base_q <= '0; raw_w2_q <= '0; raw_w3_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: if (sub_start) begin
                    srcsel_q <= src_sel; dst_q <= dst_sel; idx_q <= index;
                    elev_q <= elevated; fault_q <= FLT_NONE;
                    if (direct_valid) token_q <= direct_token;
                end
                S_READ_SRC:     src_q <= src_rd;
                S_CHECK_ACCESS: if (!perm_ok) fault_q <= FLT_PERM;
                                else if (!bounds_ok) fault_q <= FLT_BOUNDS;
                S_TOK_WAIT:     token_q <= mem_rdata;
                S_CHECK_NS:     if (!slot_ok) fault_q <= FLT_NSLIM;
                S_WAIT_GATE: begin
                    if (gate_fault) fault_q <= gate_fault_kind ? FLT_SEAL : FLT_VERSION;
                    else if (gate_done) begin
                        raw_base_q <= gate_raw_base; raw_w2_q <= gate_raw_w2; raw_w3_q <= gate_raw_w3;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        gate_start = 1'b0;
        sub_done   = 1'b0;
        sub_fault  = 1'b0;
        unique case (state_q)
            S_FETCH_TOK: begin
                mem_rd_en = !gate_busy;
                mem_addr  = ADDR_W'(src_q.w1 + 32'(idx_q));
            end
            S_CLEAR_GBIT: begin
                mem_wr_en = !gate_busy;
                mem_addr  = ADDR_W'(ns_reg.w1 + 32'(slot) * 32'd3 + 32'd2);
                mem_wdata = raw_w3_q & ~(32'd1 << GBIT_POS);
            end
            S_MIRROR: begin
                mem_wr_en = !gate_busy;
                mem_addr  = ADDR_W'(MIRROR_BASE + 32'(dst_q));
                mem_wdata = token_q;
            end
            S_START_GATE: gate_start = 1'b1;
            S_COMPLETE:   sub_done   = 1'b1;
            S_FAULT:      sub_fault  = 1'b1;
            default: ;
        endcase
    end

    assign gate_token   = token_q;
    assign gate_ns_base = ns_reg.w1;
    assign fault_code   = fault_q;

    assert_perm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_TOK) |-> (src_q.w0[LOAD_PERM_BIT] || elev_q));
    assert_index_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_TOK) |-> (idx_q < src_q.w0[LIMIT_LSB +: IDX_W]));
    assert_slot_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_start |-> (32'(gate_token[SLOT_W-1:0]) < ns_reg.w2));
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_start |=> !gate_start);
    assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_busy |-> (!mem_rd_en && !mem_wr_en));
    assert_fault_coded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_fault |-> (fault_code != 3'd0));
    assert_mirror_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_addr >= ADDR_W'(MIRROR_BASE)) |-> (32'(dst_q) <= 32'(MIRROR_MAX)));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sub_done |=> !sub_done);
endmodule

// File: tb/test_cap_loader.sv
module test_cap_loader;
    localparam int NSB = 512;
    localparam int NSLIM = 200;
    localparam int MIRB = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic sub_start = 0, direct_valid = 0, elevated = 0;
    logic [3:0] src_sel = 0, dst_sel = 0, rf_wr_sel = 0, rf_rd_sel = 0;
    logic [11:0] index = 0;
    logic [31:0] direct_token = 0;
    logic rf_wr_en = 0;
    logic [95:0] rf_wr_data = 0, rf_rd_data;
    logic sub_done, sub_fault, mem_rd_en, mem_wr_en, gate_start;
    logic [2:0] fault_code;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, gate_token, gate_ns_base;
    logic g_busy = 0, g_done = 0, g_fault = 0, g_kind = 0;
    logic [31:0] g_tok = 0;
    int g_mode = 0, g_lat = 0, g_cnt = 0, starts = 0, conflicts = 0;
    int checks = 0, errors = 0;
    logic [31:0] mem [0:2047];

    cap_loader i_cap_loader (
        .clk(clk), .rst_n(rst_n), .sub_start(sub_start), .src_sel(src_sel), .dst_sel(dst_sel),
        .index(index), .direct_valid(direct_valid), .direct_token(direct_token), .elevated(elevated),
        .sub_done(sub_done), .sub_fault(sub_fault), .fault_code(fault_code),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .gate_start(gate_start), .gate_token(gate_token),
        .gate_ns_base(gate_ns_base), .gate_busy(g_busy), .gate_done(g_done), .gate_fault(g_fault),
        .gate_fault_kind(g_kind), .gate_raw_base(g_tok ^ 32'hA5A5_0000), .gate_raw_w2(g_tok + 32'd7),
        .gate_raw_w3(g_tok | 32'h0001_0000), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
        .rf_wr_data(rf_wr_data), .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data)
    );

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[10:0]];
        if (mem_wr_en) mem[mem_addr[10:0]] <= mem_wdata;
        if (g_busy && (mem_rd_en || mem_wr_en)) conflicts <= conflicts + 1;
    end

    // integrity gate model: busy for g_lat+1 cycles, then done or fault
    always @(posedge clk) begin
        g_done <= 1'b0;
        g_fault <= 1'b0;
        if (gate_start) begin
            g_busy <= 1'b1; g_cnt <= g_lat; g_tok <= gate_token; starts <= starts + 1;
        end else if (g_busy) begin
            if (g_cnt == 0) begin
                g_busy <= 1'b0;
                if (g_mode == 0) g_done <= 1'b1;
                else begin g_fault <= 1'b1; g_kind <= (g_mode == 2); end
            end else g_cnt <= g_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_code(input bit direct, input bit lperm, input int lim, input int idx,
                                    input bit elev, input logic [31:0] tok, input int mode);
        if (!direct && !(lperm || elev)) return 1;
        if (!direct && idx >= lim) return 2;
        if (int'(tok[11:0]) >= NSLIM) return 3;
        if (mode == 1) return 4;
        if (mode == 2) return 5;
        return 0;
    endfunction

    task automatic rf_write(input int sel, input logic [95:0] d);
        @(negedge clk);
        rf_wr_en = 1; rf_wr_sel = 4'(sel); rf_wr_data = d;
        @(negedge clk);
        rf_wr_en = 0;
    endtask

    task automatic run_op(input int src, input int dst, input bit lperm, input int lim, input int base,
                          input int idx, input bit direct, input logic [31:0] tok, input bit elev,
                          input int mode, input int lat, input string tag);
        int code, s0, cyc, gaddr;
        logic [31:0] w0;
        code = exp_code(direct, lperm, lim, idx, elev, tok, mode);
        w0 = {4'd0, 12'(lim), 15'd0, lperm};
        rf_write(dst, {3{32'hBAD0_0000 + 32'(dst)}});
        rf_write(src, {32'd0, 32'(base), w0});
        if (!direct) mem[base + idx] = tok;
        mem[MIRB + dst] = 32'hDEAD_BEEF;
        gaddr = NSB + 3 * int'(tok[11:0]) + 2;
        if (int'(tok[11:0]) < NSLIM) mem[gaddr] = 32'h5555_5555;
        g_mode = mode; g_lat = lat; s0 = starts;
        @(negedge clk);
        sub_start = 1; src_sel = 4'(src); dst_sel = 4'(dst); index = 12'(idx);
        direct_valid = direct; direct_token = direct ? tok : 32'h0; elevated = elev;
        @(negedge clk);
        sub_start = 0;
        cyc = 0;
        while (!(sub_done || sub_fault) && cyc < 200) begin @(negedge clk); cyc++; end
        chk(cyc < 200, {tag, " R11 completion"}, 96'(cyc), 96'(0));
        chk(int'(fault_code) == code && (sub_fault == (code != 0)),
            {tag, code == 1 ? " R3" : code == 2 ? " R4" : code == 3 ? " R6" : code >= 4 ? " R8" : " R11", " fault code"},
            96'(fault_code), 96'(code));
        @(negedge clk);
        rf_rd_sel = 4'(dst);
        #0.1;
        chk(starts - s0 == ((code == 0 || code >= 4) ? 1 : 0), {tag, " R6 gate starts"},
            96'(starts - s0), 96'((code == 0 || code >= 4) ? 1 : 0));
        if (code == 0 || code >= 4)
            chk(g_tok == tok, {tag, direct ? " R2" : " R5", " token"}, 96'(g_tok), 96'(tok));
        if (code == 0) begin
            chk(rf_rd_data == {tok + 32'd7, tok ^ 32'hA5A5_0000, tok}, {tag, " R11 dest reg"},
                rf_rd_data, {tok + 32'd7, tok ^ 32'hA5A5_0000, tok});
            chk(mem[gaddr] == (tok & ~32'h0001_0000), {tag, " R9 gbit word"},
                96'(mem[gaddr]), 96'(tok & ~32'h0001_0000));
            chk(mem[MIRB + dst] == ((dst <= 7) ? tok : 32'hDEAD_BEEF), {tag, " R10 mirror"},
                96'(mem[MIRB + dst]), 96'((dst <= 7) ? tok : 32'hDEAD_BEEF));
        end else begin
            chk(rf_rd_data == {3{32'hBAD0_0000 + 32'(dst)}}, {tag, " R8 dest untouched"},
                rf_rd_data, {3{32'hBAD0_0000 + 32'(dst)}});
            chk(mem[MIRB + dst] == 32'hDEAD_BEEF, {tag, " R8 mirror untouched"},
                96'(mem[MIRB + dst]), 96'(32'hDEAD_BEEF));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!sub_done && !sub_fault && !mem_rd_en && !mem_wr_en && !gate_start && fault_code == 0,
            "R1 outputs idle", {91'd0, sub_done, sub_fault, mem_rd_en, mem_wr_en, gate_start}, 96'd0);
        rf_rd_sel = 4'd3;
        #0.1;
        chk(rf_rd_data == 96'd0, "R1 register cleared", rf_rd_data, 96'd0);
        rst_n = 1;
        rf_write(15, {32'(NSLIM), 32'(NSB), 32'd0});

        // directed corner cases
        run_op(0, 1, 0, 10, 20, 3, 0, 32'h0001_2005, 0, 0, 1, "perm-missing R3");
        run_op(0, 1, 0, 10, 20, 3, 0, 32'h0001_2005, 1, 0, 1, "elevated R3");
        run_op(2, 3, 1, 10, 40, 10, 0, 32'h0000_3006, 0, 0, 0, "idx==limit R4");
        run_op(2, 3, 1, 10, 40, 9, 0, 32'h0000_3006, 0, 0, 0, "idx==limit-1 R4");
        run_op(4, 5, 1, 8, 60, 2, 0, 32'h7000_00C7, 0, 0, 2, "slot199 R6");
        run_op(4, 5, 1, 8, 60, 2, 0, 32'h7000_00C8, 0, 0, 2, "slot200 R6");
        run_op(6, 2, 0, 0, 0, 50, 1, 32'h1234_5010, 0, 0, 1, "direct R2");
        run_op(1, 7, 1, 5, 80, 1, 0, 32'h0BAD_1011, 0, 1, 3, "version R8");
        run_op(1, 7, 1, 5, 80, 1, 0, 32'h0BAD_1012, 0, 2, 0, "seal R8");
        run_op(3, 7, 1, 5, 90, 4, 0, 32'hCAFE_0020, 0, 0, 2, "dst7 R10");
        run_op(3, 8, 1, 5, 90, 4, 0, 32'hCAFE_0021, 0, 0, 2, "dst8 R10");

        // constrained random loads
        for (int n = 0; n < 60; n++) begin
            int src, dst, lim, base, idx, mode, r;
            logic [31:0] tok;
            src = $urandom % 15;
            dst = (src + 1 + $urandom % 14) % 15;
            lim = 1 + $urandom % 64;
            base = $urandom % 192;
            idx = $urandom % (lim + 4);
            r = $urandom % 10;
            mode = (r < 7) ? 0 : (r < 9 ? 1 : 2);
            tok = {20'($urandom), 12'($urandom % 256)};
            run_op(src, dst, ($urandom % 4) != 0, lim, base, idx, ($urandom % 5) == 0, tok,
                   ($urandom % 6) == 0, mode, $urandom % 5, "random R5");
        end

        chk(conflicts == 0, "R7 bus quiet while gate busy", 96'(conflicts), 96'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule